// File: doc/BRIEF.md
# Out-of-Order Issue Buffer with Tag Wakeup

This block sits between an in-order decode stage and a functional unit. Each decoded instruction is written into a free slot in the buffer, so decode does not stall on a missing source. Each of the instruction's two source operands arrives either as a finished value or as the tag of the instruction that will produce it. Every slot watches a single result broadcast channel. When a broadcast carries the tag that a pending operand recorded, the slot copies the broadcast data into that operand.

A slot whose operands are all present becomes eligible to go to the functional unit. The issue port picks one eligible slot per cycle, always the lowest-numbered one, and ignores the order in which the instructions arrived. Instructions therefore enter in program order but can leave in any order. A valid/ready handshake moves an instruction out, and the slot becomes free again on that same clock edge.

Each slot runs a small state machine with three states: `ENT_FREE` (empty), `ENT_WAIT` (holding at least one pending tag) and `ENT_READY` (all operands present, eligible to issue). Its transitions are:
- *fill-ready* (FREE→READY): the slot is allocated and every operand is present after capture.
- *fill-wait* (FREE→WAIT): the slot is allocated and some operand is still missing.
- *wake* (WAIT→READY): the last missing operand is captured.
- *keep-waiting* (WAIT→WAIT).
- *drain* (READY→FREE): the instruction issues.
- *hold* (READY→READY): the instruction is offered but not accepted.

Top module: `rs_station`

## Requirements
- R1: An accepted allocation (`alloc_valid` high and `alloc_full` low) writes the lowest-index free slot, so a slot freed by issue is reused before any higher-index free slot.
- R2: `alloc_full` is high exactly when no slot is free. An allocation offered while it is high is dropped and never appears at the issue port.
- R3: A source flagged ready at allocation is stored as a value, and later broadcasts with any tag leave it unchanged.
- R4: A source not flagged ready stores its tag. It takes `bc_data` on the first cycle that `bc_valid` is high with `bc_tag` equal to that tag.
- R5: A broadcast in the same cycle as the allocation of a pending source with the matching tag is captured by that source.
- R6: A slot becomes eligible only when both sources hold values. A slot whose last source is captured in cycle t is offered no earlier than cycle t+1.
- R7: When several slots are eligible, the issue port shows the lowest-index one, whatever their arrival order. `iss_op`, `iss_src_a`, `iss_src_b` and `iss_dst` carry that slot's fields.
- R8: `iss_valid` and `iss_ready` both high frees the offered slot at that edge. While `iss_ready` is low, the offered slot stays offered.
- R9: Reset empties every slot: `iss_valid` low and `alloc_full` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | OP_W | Operation code |
| alloc_a_rdy | input | 1 | Source A is a value (1) or a tag (0) |
| alloc_a_val | input | DATA_W | Source A value |
| alloc_a_tag | input | TAG_W | Source A producer tag |
| alloc_b_rdy | input | 1 | Source B is a value (1) or a tag (0) |
| alloc_b_val | input | DATA_W | Source B value |
| alloc_b_tag | input | TAG_W | Source B producer tag |
| alloc_dst | input | TAG_W | Tag of this instruction's own result |
| alloc_full | output | 1 | No free slot; allocation dropped |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast result tag |
| bc_data | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | An eligible instruction is offered |
| iss_ready | input | 1 | Functional unit accepts the offer |
| iss_op | output | OP_W | Offered operation |
| iss_src_a | output | DATA_W | Offered source A value |
| iss_src_b | output | DATA_W | Offered source B value |
| iss_dst | output | TAG_W | Offered destination tag |

## Verification
The bound checker watches four things on every cycle. It checks that at most one slot is written and at most one is offered. It checks that `alloc_full` never rises while a slot is free, and that occupancy changes only by accepted allocations and issues. It also checks that an unaccepted offer is still offered in the next cycle. Several behaviours can be seen only through the bench's scenarios at the issue port: the value captured on a tag match, a ready operand ignoring broadcasts, same-cycle capture during allocation, the one-cycle wake delay, and issue out of arrival order.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_READY = 2'd2
    } ent_state_e;

endpackage

// File: rtl/rs_slot.sv
// One source operand: either a held value or a pending producer tag.
module rs_slot #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_rdy,
    input  logic [DATA_W-1:0] ld_val,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              listen,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              have_nxt,
    output logic [DATA_W-1:0] val
);

    logic              have_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;
    logic              hit_ld;
    logic              hit_live;

    always_comb begin
        hit_ld   = bc_valid && (bc_tag == ld_tag);
        hit_live = listen && !have_q && bc_valid && (bc_tag == tag_q);
        if (load) begin
            have_nxt = ld_rdy || hit_ld;
        end else begin
            have_nxt = have_q || hit_live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            tag_q  <= '0;
            val_q  <= '0;
        end else if (load) begin
            tag_q <= ld_tag;
            if (ld_rdy) begin
                have_q <= 1'b1;
                val_q  <= ld_val;
            end else if (hit_ld) begin
                have_q <= 1'b1;
                val_q  <= bc_data;
            end else begin
                have_q <= 1'b0;
            end
        end else if (hit_live) begin
            have_q <= 1'b1;
            val_q  <= bc_data;
        end
    end

    assign val = val_q;

endmodule

// File: rtl/rs_entry.sv
// One buffer slot: state machine plus its operands and payload.
module rs_entry
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 4,
    parameter int NSRC   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_we,
    input  logic [OP_W-1:0]              alloc_op,
    input  logic [NSRC-1:0]              alloc_rdy,
    input  logic [NSRC-1:0][DATA_W-1:0]  alloc_val,
    input  logic [NSRC-1:0][TAG_W-1:0]   alloc_tag,
    input  logic [TAG_W-1:0]             alloc_dst,
    input  logic                         bc_valid,
    input  logic [TAG_W-1:0]             bc_tag,
    input  logic [DATA_W-1:0]            bc_data,
    input  logic                         take,
    output logic                         is_free,
    output logic                         is_ready,
    output logic [OP_W-1:0]              ent_op,
    output logic [NSRC-1:0][DATA_W-1:0]  ent_val,
    output logic [TAG_W-1:0]             ent_dst
);

    ent_state_e      state_q;
    ent_state_e      state_d;
    logic [NSRC-1:0] have_nxt;
    logic            listen;
    logic [OP_W-1:0] op_q;
    logic [TAG_W-1:0] dst_q;

    assign listen = (state_q == ENT_WAIT);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rs_slot #(
            .DATA_W(DATA_W),
            .TAG_W (TAG_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (alloc_we),
            .ld_rdy  (alloc_rdy[s]),
            .ld_val  (alloc_val[s]),
            .ld_tag  (alloc_tag[s]),
            .listen  (listen),
            .bc_valid(bc_valid),
            .bc_tag  (bc_tag),
            .bc_data (bc_data),
            .have_nxt(have_nxt[s]),
            .val     (ent_val[s])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: begin
                if (alloc_we) begin
                    state_d = (&have_nxt) ? ENT_READY : ENT_WAIT;   // fill-ready / fill-wait
                end
            end
            ENT_WAIT: begin
                if (&have_nxt) begin
                    state_d = ENT_READY;                           // wake
                end
            end
            ENT_READY: begin
                if (take) begin
                    state_d = ENT_FREE;                            // drain
                end
            end
            default: state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            dst_q <= '0;
        end else if (alloc_we) begin
            op_q  <= alloc_op;
            dst_q <= alloc_dst;
        end
    end

    // outputs
    always_comb begin
        is_free  = 1'b0;
        is_ready = 1'b0;
        unique case (state_q)
            ENT_FREE:  is_free  = 1'b1;
            ENT_WAIT:  is_ready = 1'b0;
            ENT_READY: is_ready = 1'b1;
            default:   is_free  = 1'b1;
        endcase
        ent_op  = op_q;
        ent_dst = dst_q;
    end

endmodule

// File: rtl/rs_lowpick.sv
// Lowest-index one-hot selector.
module rs_lowpick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int DATA_W  = 16,
    parameter int TAG_W   = 4,
    parameter int OP_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic              alloc_a_rdy,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic              alloc_b_rdy,
    input  logic [DATA_W-1:0] alloc_b_val,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [TAG_W-1:0]  alloc_dst,
    output logic              alloc_full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_op,
    output logic [DATA_W-1:0] iss_src_a,
    output logic [DATA_W-1:0] iss_src_b,
    output logic [TAG_W-1:0]  iss_dst
);

    localparam int NSRC = 2;

    logic [NUM_ENT-1:0] ent_free;
    logic [NUM_ENT-1:0] ent_ready;
    logic [NUM_ENT-1:0] alloc_grant;
    logic [NUM_ENT-1:0] iss_grant;
    logic               free_any;
    logic               ready_any;
    logic               alloc_fire;
    logic               iss_fire;

    logic [NSRC-1:0]             src_rdy;
    logic [NSRC-1:0][DATA_W-1:0] src_val;
    logic [NSRC-1:0][TAG_W-1:0]  src_tag;

    logic [OP_W-1:0]             e_op  [NUM_ENT];
    logic [NSRC-1:0][DATA_W-1:0] e_val [NUM_ENT];
    logic [TAG_W-1:0]            e_dst [NUM_ENT];

    assign src_rdy = {alloc_b_rdy, alloc_a_rdy};
    assign src_val = {alloc_b_val, alloc_a_val};
    assign src_tag = {alloc_b_tag, alloc_a_tag};

    rs_lowpick #(.N(NUM_ENT)) u_free_pick (
        .req  (ent_free),
        .grant(alloc_grant),
        .any  (free_any)
    );

    rs_lowpick #(.N(NUM_ENT)) u_iss_pick (
        .req  (ent_ready),
        .grant(iss_grant),
        .any  (ready_any)
    );

    assign alloc_full = !free_any;
    assign alloc_fire = alloc_valid && free_any;
    assign iss_valid  = ready_any;
    assign iss_fire   = ready_any && iss_ready;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        rs_entry #(
            .DATA_W(DATA_W),
            .TAG_W (TAG_W),
            .OP_W  (OP_W),
            .NSRC  (NSRC)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_we (alloc_fire && alloc_grant[e]),
            .alloc_op (alloc_op),
            .alloc_rdy(src_rdy),
            .alloc_val(src_val),
            .alloc_tag(src_tag),
            .alloc_dst(alloc_dst),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .take     (iss_fire && iss_grant[e]),
            .is_free  (ent_free[e]),
            .is_ready (ent_ready[e]),
            .ent_op   (e_op[e]),
            .ent_val  (e_val[e]),
            .ent_dst  (e_dst[e])
        );
    end

    // AND-OR mux of the granted slot onto the issue port
    always_comb begin
        iss_op    = '0;
        iss_src_a = '0;
        iss_src_b = '0;
        iss_dst   = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            iss_op    |= e_op[e]     & {OP_W{iss_grant[e]}};
            iss_src_a |= e_val[e][0] & {DATA_W{iss_grant[e]}};
            iss_src_b |= e_val[e][1] & {DATA_W{iss_grant[e]}};
            iss_dst   |= e_dst[e]    & {TAG_W{iss_grant[e]}};
        end
    end

endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
    parameter int NUM_ENT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_ENT-1:0] ent_free,
    input logic [NUM_ENT-1:0] alloc_grant,
    input logic [NUM_ENT-1:0] iss_grant,
    input logic               alloc_fire,
    input logic               iss_fire,
    input logic               alloc_full,
    input logic               iss_valid,
    input logic               iss_ready
);

    // R1
    one_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_grant));

    // R7
    one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_grant));

    // R2
    full_no_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_full |-> (ent_free == '0));

    // R8
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            (int'($countones(~ent_free)) ==
             int'($countones(~$past(ent_free))) + int'($past(alloc_fire)) - int'($past(iss_fire))));

    // R8
    hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> iss_valid);

endmodule

bind rs_station rs_station_chk #(.NUM_ENT(NUM_ENT)) u_rs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_free   (ent_free),
    .alloc_grant(alloc_grant),
    .iss_grant  (iss_grant),
    .alloc_fire (alloc_fire),
    .iss_fire   (iss_fire),
    .alloc_full (alloc_full),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready)
);

// File: tb/tb_rs_station.sv
`timescale 1ns/1ps
module tb_rs_station;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [3:0]  alloc_op = '0;
    logic        alloc_a_rdy = 1'b0;
    logic [15:0] alloc_a_val = '0;
    logic [3:0]  alloc_a_tag = '0;
    logic        alloc_b_rdy = 1'b0;
    logic [15:0] alloc_b_val = '0;
    logic [3:0]  alloc_b_tag = '0;
    logic [3:0]  alloc_dst = '0;
    logic        alloc_full;
    logic        bc_valid = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [15:0] bc_data = '0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [3:0]  iss_op;
    logic [15:0] iss_src_a;
    logic [15:0] iss_src_b;
    logic [3:0]  iss_dst;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rs_station dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_a_rdy(alloc_a_rdy), .alloc_a_val(alloc_a_val), .alloc_a_tag(alloc_a_tag),
        .alloc_b_rdy(alloc_b_rdy), .alloc_b_val(alloc_b_val), .alloc_b_tag(alloc_b_tag),
        .alloc_dst(alloc_dst), .alloc_full(alloc_full),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst)
    );

    typedef struct packed {
        logic        av;
        logic [3:0]  aop;
        logic        ar;
        logic [15:0] aa;     // value if ar, else tag in low bits
        logic        br;
        logic [15:0] bb;
        logic [3:0]  dst;
        logic        bv;
        logic [3:0]  btag;
        logic [15:0] bdata;
        logic        ird;
        logic        efull;
        logic        eiv;
        logic [3:0]  eop;
        logic [15:0] ea;
        logic [15:0] eb;
        logic [3:0]  edst;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        // R9 empty after reset; R1 first slot written
        '{1'b1,4'd1, 1'b1,16'h0011, 1'b1,16'h0022, 4'd1, 1'b0,4'd0,16'h0, 1'b0, 1'b0,1'b0,4'd0,16'h0,16'h0,4'd0, 4'd9},
        // R3 ready-at-alloc instruction offered next cycle
        '{1'b1,4'd2, 1'b0,16'h0005, 1'b1,16'h0033, 4'd2, 1'b0,4'd0,16'h0, 1'b0, 1'b0,1'b1,4'd1,16'h0011,16'h0022,4'd1, 4'd3},
        // R8 held while not accepted
        '{1'b1,4'd3, 1'b1,16'h0044, 1'b0,16'h0006, 4'd3, 1'b0,4'd0,16'h0, 1'b0, 1'b0,1'b1,4'd1,16'h0011,16'h0022,4'd1, 4'd8},
        '{1'b1,4'd4, 1'b0,16'h0007, 1'b0,16'h0007, 4'd4, 1'b0,4'd0,16'h0, 1'b0, 1'b0,1'b1,4'd1,16'h0011,16'h0022,4'd1, 4'd8},
        // R2 full: op 9 offered and dropped; slot 0 issues
        '{1'b1,4'd9, 1'b1,16'hEEEE, 1'b1,16'hEEEE, 4'd9, 1'b0,4'd0,16'h0, 1'b1, 1'b1,1'b1,4'd1,16'h0011,16'h0022,4'd1, 4'd2},
        // R6 nothing eligible; tag 6 broadcast
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b1,4'd6,16'h0066, 1'b1, 1'b0,1'b0,4'd0,16'h0,16'h0,4'd0, 4'd6},
        // R6 R7 slot 2 issues ahead of slot 1 that is captured this very cycle
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b1,4'd5,16'h0055, 1'b1, 1'b0,1'b1,4'd3,16'h0044,16'h0066,4'd3, 4'd7},
        // R4 tag 5 captured; tag 7 fills both sources of slot 3; R1 op5 to slot 0
        '{1'b1,4'd5, 1'b1,16'h0077, 1'b1,16'h0088, 4'd5, 1'b1,4'd7,16'h0099, 1'b0, 1'b0,1'b1,4'd2,16'h0055,16'h0033,4'd2, 4'd4},
        // R1 R7 reused slot 0 wins over older slot 1
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b0,4'd0,16'h0, 1'b1, 1'b0,1'b1,4'd5,16'h0077,16'h0088,4'd5, 4'd1},
        // R7 then slot 1; stray tag 7 broadcast
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b1,4'd7,16'hAAAA, 1'b1, 1'b0,1'b1,4'd2,16'h0055,16'h0033,4'd2, 4'd7},
        // R3 captured values untouched by stray broadcast
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b0,4'd0,16'h0, 1'b1, 1'b0,1'b1,4'd4,16'h0099,16'h0099,4'd4, 4'd3},
        // R2 dropped op 9 never appears
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b0,4'd0,16'h0, 1'b1, 1'b0,1'b0,4'd0,16'h0,16'h0,4'd0, 4'd2},
        // R5 allocation with same-cycle matching broadcast
        '{1'b1,4'd6, 1'b0,16'h0008, 1'b1,16'h0012, 4'd6, 1'b1,4'd8,16'h1234, 1'b1, 1'b0,1'b0,4'd0,16'h0,16'h0,4'd0, 4'd5},
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b0,4'd0,16'h0, 1'b0, 1'b0,1'b1,4'd6,16'h1234,16'h0012,4'd6, 4'd5},
        // R8 accepted
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b0,4'd0,16'h0, 1'b1, 1'b0,1'b1,4'd6,16'h1234,16'h0012,4'd6, 4'd8},
        // R8 slot freed
        '{1'b0,4'd0, 1'b0,16'h0, 1'b0,16'h0, 4'd0, 1'b0,4'd0,16'h0, 1'b0, 1'b0,1'b0,4'd0,16'h0,16'h0,4'd0, 4'd8}
    };

    task automatic check_out(input int req, input logic ef, input logic eiv,
                             input logic [3:0] eop, input logic [15:0] ea,
                             input logic [15:0] eb, input logic [3:0] ed);
        logic ok;
        n_run++;
        ok = (alloc_full === ef) && (iss_valid === eiv);
        if (eiv && ok) begin
            ok = (iss_op === eop) && (iss_src_a === ea) && (iss_src_b === eb) && (iss_dst === ed);
        end
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: full=%b v=%b op=%h a=%h b=%h d=%h expected full=%b v=%b op=%h a=%h b=%h d=%h",
                     req, alloc_full, iss_valid, iss_op, iss_src_a, iss_src_b, iss_dst,
                     ef, eiv, eop, ea, eb, ed);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 1'b0;
        bc_valid    = 1'b0;
        iss_ready   = 1'b0;
    endtask

    task automatic put_ready(input logic [3:0] op, input logic [15:0] a);
        alloc_valid = 1'b1; alloc_op = op;
        alloc_a_rdy = 1'b1; alloc_a_val = a;
        alloc_b_rdy = 1'b1; alloc_b_val = a + 16'd1;
        alloc_dst   = op;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            alloc_valid = VEC[i].av;  alloc_op = VEC[i].aop;
            alloc_a_rdy = VEC[i].ar;  alloc_a_val = VEC[i].aa;  alloc_a_tag = VEC[i].aa[3:0];
            alloc_b_rdy = VEC[i].br;  alloc_b_val = VEC[i].bb;  alloc_b_tag = VEC[i].bb[3:0];
            alloc_dst   = VEC[i].dst;
            bc_valid    = VEC[i].bv;  bc_tag = VEC[i].btag;     bc_data = VEC[i].bdata;
            iss_ready   = VEC[i].ird;
            #1;
            check_out(int'(VEC[i].req), VEC[i].efull, VEC[i].eiv,
                      VEC[i].eop, VEC[i].ea, VEC[i].eb, VEC[i].edst);
        end

        // directed: fill all four, then drain in slot order (R1, R2, R7)
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle_inputs();
            put_ready(4'(k + 10), 16'(16'h0100 * (k + 1)));
        end
        @(negedge clk);
        idle_inputs();
        #1;
        check_out(2, 1'b1, 1'b1, 4'd10, 16'h0100, 16'h0101, 4'd10);   // R2 full
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            iss_ready = 1'b1;
            #1;
            // R7 lowest slot first, arrival order here matches slot order (R1)
            check_out(7, (k == 0), 1'b1, 4'(k + 10), 16'(16'h0100 * (k + 1)),
                      16'(16'h0100 * (k + 1) + 1), 4'(k + 10));
        end
        @(negedge clk);
        idle_inputs();
        #1;
        check_out(8, 1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 4'd0);

        // directed: reset in the middle of traffic (R9)
        @(negedge clk);
        put_ready(4'd3, 16'h0300);
        @(negedge clk);
        idle_inputs();
        #1;
        check_out(1, 1'b0, 1'b1, 4'd3, 16'h0300, 16'h0301, 4'd3);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_out(9, 1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 4'd0);   // R9 cleared

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule